// File: doc/BRIEF.md
# Period-Limited Timer with Synchronized Enable

The block is an up-counting timer whose count advances on edges of a slow external timer clock. That clock is oversampled in the system clock domain, so every register of the block sits in one clock domain. Software sets a period limit. When the count already equals that limit, the next active timer edge returns the count to zero and raises a one-cycle match pulse. A configuration register chooses which edge of the timer clock is active. It can also delay the start of counting by two active edges so that enabling the timer never produces a partial first tick. A third option holds each count step until a fixed phase of a divide-by-four strobe of the system clock, so that reads of the count see updates only at predictable cycles.

Software reaches the block through a one-cycle write port and a combinational read port, both using two address bits: 0 is the count, 1 is the period, 2 is the configuration and 3 is the run register. In the configuration byte, bit 7 selects phase-aligned stepping, bit 6 selects the falling edge, bit 5 selects the delayed start, and bits 4:0 hold a mode code. The mode code is stored and read back, but every code runs the timer freely. Bit 0 of the run register enables counting. The timer clock must stay at each level for at least eight system clock cycles.

Top module: `lim_timer`

## Requirements
- R1: After reset, the count, period, configuration and run registers all read 0, and match_o is low.
- R2: With bit 6 of the configuration at 0, each rising edge of tclk_in advances the count by one and falling edges leave it unchanged.
- R3: With bit 6 at 1, each falling edge advances the count and rising edges leave it unchanged.
- R4: With bit 5 of the configuration at 0, the first active edge after the run bit is set already advances the count.
- R5: With bit 5 at 1, the first two active edges after the run bit is set are absorbed and the third advances the count.
- R6: An active edge that finds the count equal to the period sets the count to 0, and match_o is high for exactly one system clock cycle, together with the count reading 0.
- R7: While the run bit is 0, timer edges leave the count unchanged.
- R8: A configuration write while the run bit is 1 leaves bit 6 unchanged and stores the other bits. A nonzero mode code counts exactly like code 0.
- R9: If the period is set below the current count, the count keeps climbing to 255, wraps to 0 without a match pulse, and then wraps at the new period.
- R10: With bit 7 of the configuration at 1, every count step lands on a cycle of the same phase modulo four system clock cycles, and no active edge is lost.
- R11: A write to address 0 loads the count, and the written value is read back on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tclk_in | input | 1 | External timer clock, oversampled |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 2 | Write address: 0 count, 1 period, 2 configuration, 3 run |
| wr_data | input | W | Write data |
| rd_addr | input | 2 | Read address, same map as wr_addr |
| rd_data | output | W | Combinational read data |
| match_o | output | 1 | One-cycle pulse on a period wrap |

## Verification
The case that is hardest to reach from the ports is the climb past a period that has just been lowered below the count. To get there, the bench loads the count above a freshly written small period and drives more than two hundred active edges. It checks every step through the overflow and counts the match pulses, expecting exactly one. The phase alignment in R10 cannot be seen from any single read. Instead, a monitor records the cycle of every count change and requires all of them to share one residue modulo four. The delayed start is checked by reading the count after each of the first three active edges that follow a fresh enable.

// File: rtl/lim_timer_pkg.sv
package lim_timer_pkg;

  typedef enum logic [1:0] {
    ADDR_COUNT  = 2'd0,
    ADDR_PERIOD = 2'd1,
    ADDR_CFG    = 2'd2,
    ADDR_RUN    = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic       psync;
    logic       pol;
    logic       esync;
    logic [4:0] mode;
  } cfg_t;

  localparam int CFG_BITS = $bits(cfg_t);

endpackage

// File: rtl/lim_timer_regs.sv
module lim_timer_regs
  import lim_timer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_addr,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] period,
  output cfg_t         cfg,
  output logic         en,
  output logic         cnt_wr,
  output logic [W-1:0] cnt_wdata
);

  logic [W-1:0] period_q, period_d;
  cfg_t         cfg_q, cfg_d;
  logic         en_q, en_d;
  logic         sel_cnt, sel_per, sel_cfg, sel_run;

  always_comb begin
    sel_cnt = wr_en && (wr_addr == ADDR_COUNT);
    sel_per = wr_en && (wr_addr == ADDR_PERIOD);
    sel_cfg = wr_en && (wr_addr == ADDR_CFG);
    sel_run = wr_en && (wr_addr == ADDR_RUN);
  end

  always_comb begin
    period_d = period_q;
    cfg_d    = cfg_q;
    en_d     = en_q;
    if (sel_per) period_d = wr_data;
    if (sel_cfg) begin
      cfg_d = cfg_t'(wr_data[CFG_BITS-1:0]);
      // edge polarity is frozen while the timer runs
      if (en_q) cfg_d.pol = cfg_q.pol;
    end
    if (sel_run) en_d = wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      cfg_q    <= '0;
      en_q     <= 1'b0;
    end else begin
      period_q <= period_d;
      cfg_q    <= cfg_d;
      en_q     <= en_d;
    end
  end

  always_comb begin
    unique case (rd_addr)
      ADDR_COUNT:  rd_data = cnt;
      ADDR_PERIOD: rd_data = period_q;
      ADDR_CFG:    rd_data = W'(cfg_q);
      default:     rd_data = W'(en_q);
    endcase
  end

  assign period    = period_q;
  assign cfg       = cfg_q;
  assign en        = en_q;
  assign cnt_wr    = sel_cnt;
  assign cnt_wdata = wr_data;

endmodule

// File: rtl/lim_timer_edge.sv
module lim_timer_edge #(
  parameter int SYNC   = 2,
  parameter int PS_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tclk_in,
  input  logic pol,
  input  logic psync,
  output logic tick
);

  localparam int PW = (PS_DIV > 1) ? $clog2(PS_DIV) : 1;

  logic [SYNC:0] sh_q, sh_d;
  logic          level, prev, rise, fall, raw;

  always_comb sh_d = {sh_q[SYNC-1:0], tclk_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  always_comb begin
    level = sh_q[SYNC-1];
    prev  = sh_q[SYNC];
    rise  = level & ~prev;
    fall  = ~level & prev;
    raw   = pol ? fall : rise;
  end

  generate
    if (PS_DIV > 1) begin : g_align
      logic [PW-1:0] phase_q, phase_d;
      logic          pend_q, pend_d;
      logic          slot;

      always_comb begin
        slot    = (phase_q == PW'(PS_DIV - 1));
        phase_d = slot ? '0 : phase_q + 1'b1;
        pend_d  = pend_q;
        if (slot)     pend_d = 1'b0;
        else if (raw) pend_d = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          phase_q <= '0;
          pend_q  <= 1'b0;
        end else begin
          phase_q <= phase_d;
          pend_q  <= psync ? pend_d : 1'b0;
        end
      end

      assign tick = psync ? ((raw | pend_q) & slot) : raw;
    end else begin : g_direct
      assign tick = raw;
    end
  endgenerate

endmodule

// File: rtl/lim_timer_gate.sv
module lim_timer_gate #(
  parameter int DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic esync,
  input  logic tick,
  output logic inc
);

  logic [DLY-1:0] arm_q, arm_d;
  logic           run;

  always_comb begin
    arm_d = arm_q;
    if (!en)       arm_d = '0;
    else if (tick) arm_d = DLY'({arm_q, 1'b1});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= '0;
    else        arm_q <= arm_d;
  end

  always_comb begin
    run = en & (esync ? arm_q[DLY-1] : 1'b1);
    inc = tick & run;
  end

endmodule

// File: rtl/lim_timer_core.sv
module lim_timer_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic [W-1:0] period,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         match
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         match_q, match_d;
  logic         at_limit;

  always_comb begin
    at_limit = (cnt_q == period);
    cnt_d    = cnt_q;
    match_d  = 1'b0;
    if (load) begin
      cnt_d = load_val;
    end else if (inc) begin
      if (at_limit) begin
        cnt_d   = '0;
        match_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      match_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      match_q <= match_d;
    end
  end

  assign cnt   = cnt_q;
  assign match = match_q;

endmodule

// File: rtl/lim_timer.sv
module lim_timer
  import lim_timer_pkg::*;
#(
  parameter int W         = 8,
  parameter int SYNC      = 2,
  parameter int START_DLY = 2,
  parameter int PS_DIV    = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tclk_in,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_addr,
  output logic [W-1:0] rd_data,
  output logic         match_o
);

  logic [1:0]   rst_sh_q;
  logic         rst_q_n;
  logic [W-1:0] cnt, period, cnt_wdata;
  cfg_t         cfg;
  logic         en, cnt_wr, tick, inc, match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= '0;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_q_n = rst_sh_q[1];

  lim_timer_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_q_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .cnt(cnt), .rd_data(rd_data),
    .period(period), .cfg(cfg), .en(en), .cnt_wr(cnt_wr),
    .cnt_wdata(cnt_wdata)
  );

  lim_timer_edge #(.SYNC(SYNC), .PS_DIV(PS_DIV)) u_edge (
    .clk(clk), .rst_n(rst_q_n), .tclk_in(tclk_in), .pol(cfg.pol),
    .psync(cfg.psync), .tick(tick)
  );

  lim_timer_gate #(.DLY(START_DLY)) u_gate (
    .clk(clk), .rst_n(rst_q_n), .en(en), .esync(cfg.esync),
    .tick(tick), .inc(inc)
  );

  lim_timer_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_q_n), .inc(inc), .period(period),
    .load(cnt_wr), .load_val(cnt_wdata), .cnt(cnt), .match(match)
  );

  assign match_o = match;

endmodule

// File: rtl/lim_timer_chk.sv
module lim_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         pol,
  input logic         cnt_wr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] cnt,
  input logic         match
);

  a_r6_match_single: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> !match);

  a_r6_match_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> (cnt == '0));

  a_r7_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cnt_wr) |=> (cnt == $past(cnt)));

  a_r8_pol_locked: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (pol == $past(pol)));

  a_r9_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (cnt == $past(cnt) || cnt == W'($past(cnt) + 1'b1) || cnt == '0));

  a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == $past(wdata)));

endmodule

bind lim_timer lim_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .en(en), .pol(cfg.pol), .cnt_wr(cnt_wr),
  .wdata(cnt_wdata), .cnt(cnt), .match(match)
);

// File: tb/lim_timer_test.sv
module lim_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;
  localparam int HOLD       = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         tclk_in;
  logic         wr_en;
  logic [1:0]   wr_addr;
  logic [W-1:0] wr_data;
  logic [1:0]   rd_addr;
  logic [W-1:0] rd_data;
  logic         match_o;

  int n_run  = 0;
  int n_fail = 0;
  int n_match = 0;
  int cyc = 0;
  bit mon_on = 0;
  int mon_res = -1;
  int mon_bad = 0;
  int mon_steps = 0;
  logic [W-1:0] mon_prev = '0;
  bit done = 0;

  lim_timer uut (
    .clk(clk), .rst_n(rst_n), .tclk_in(tclk_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .match_o(match_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    if (match_o) n_match++;
    if (mon_on && rd_data !== mon_prev) begin
      mon_steps++;
      if (mon_res < 0) mon_res = cyc % 4;
      else if ((cyc % 4) != mon_res) mon_bad++;
    end
    mon_prev = rd_data;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
    rd_addr = 2'd0;
    #1;
  endtask

  task automatic set_tclk(input logic v);
    if (tclk_in !== v) begin
      @(negedge clk);
      tclk_in = v;
      repeat (HOLD) @(negedge clk);
    end
  endtask

  function automatic logic [W-1:0] step(input logic [W-1:0] c, input logic [W-1:0] p);
    return (c == p) ? '0 : W'(c + 1'b1);
  endfunction

  logic [W-1:0] v, exp_c;
  int m0, exp_m;

  initial begin
    rst_n = 1'b0; tclk_in = 1'b0; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1 reset register", int'(v), 0);
    end
    check("R1 match low", int'(match_o), 0);

    // R2, R4, R6: sweep periods, rising edge, no start delay
    for (int p = 0; p < 8; p++) begin
      wr(2'd3, 8'd0);
      wr(2'd0, 8'd0);
      wr(2'd1, 8'(p));
      set_tclk(1'b0);
      wr(2'd3, 8'd1);
      exp_c = '0;
      m0 = n_match;
      exp_m = 0;
      for (int e = 0; e < 2 * (p + 1) + 1; e++) begin
        set_tclk(1'b1);
        if (exp_c == 8'(p)) exp_m++;
        exp_c = step(exp_c, 8'(p));
        rd(2'd0, v);
        if (e == 0) check("R4 first edge counts", int'(v), 1 % (p + 1));
        check("R2 rising edge step", int'(v), int'(exp_c));
        set_tclk(1'b0);
        rd(2'd0, v);
        check("R2 falling edge ignored", int'(v), int'(exp_c));
      end
      check("R6 match pulse count", n_match - m0, exp_m);
    end

    // R7: disabled timer holds count
    wr(2'd3, 8'd0);
    rd(2'd0, v);
    exp_c = v;
    for (int e = 0; e < 3; e++) begin
      set_tclk(1'b1);
      set_tclk(1'b0);
    end
    rd(2'd0, v);
    check("R7 count held while off", int'(v), int'(exp_c));

    // R8: polarity locked while running, other fields stored, mode free-running
    wr(2'd1, 8'd200);
    wr(2'd0, 8'd10);
    wr(2'd3, 8'd1);
    wr(2'd2, 8'h43);
    rd(2'd2, v);
    check("R8 cfg write while running", int'(v), 8'h03);
    set_tclk(1'b1);
    rd(2'd0, v);
    check("R8 nonzero mode still counts", int'(v), 11);
    set_tclk(1'b0);

    // R3: falling edge polarity
    wr(2'd3, 8'd0);
    wr(2'd2, 8'h40);
    rd(2'd2, v);
    check("R8 pol write while stopped", int'(v), 8'h40);
    wr(2'd0, 8'd0);
    set_tclk(1'b1);
    wr(2'd3, 8'd1);
    exp_c = '0;
    for (int e = 0; e < 4; e++) begin
      set_tclk(1'b0);
      exp_c = step(exp_c, 8'd200);
      rd(2'd0, v);
      check("R3 falling edge step", int'(v), int'(exp_c));
      set_tclk(1'b1);
      rd(2'd0, v);
      check("R3 rising edge ignored", int'(v), int'(exp_c));
    end

    // R5: delayed start, R11: count load
    wr(2'd3, 8'd0);
    wr(2'd2, 8'h20);
    set_tclk(1'b0);
    wr(2'd0, 8'd50);
    rd(2'd0, v);
    check("R11 count load readback", int'(v), 50);
    wr(2'd3, 8'd1);
    for (int e = 1; e <= 4; e++) begin
      set_tclk(1'b1);
      set_tclk(1'b0);
      rd(2'd0, v);
      check("R5 delayed start", int'(v), (e <= 2) ? 50 : 50 + e - 2);
    end

    // R9: period lowered below count
    wr(2'd3, 8'd0);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'd20);
    wr(2'd1, 8'd10);
    wr(2'd3, 8'd1);
    exp_c = 8'd20;
    m0 = n_match;
    for (int e = 0; e < 236 + 11; e++) begin
      set_tclk(1'b1);
      exp_c = step(exp_c, 8'd10);
      rd(2'd0, v);
      check("R9 climb past lowered period", int'(v), int'(exp_c));
      set_tclk(1'b0);
    end
    check("R9 final count", int'(exp_c), 0);
    check("R9 single match", n_match - m0, 1);

    // R10: phase-aligned stepping
    wr(2'd3, 8'd0);
    wr(2'd2, 8'h80);
    wr(2'd0, 8'd0);
    wr(2'd1, 8'd200);
    wr(2'd3, 8'd1);
    @(negedge clk);
    mon_prev = rd_data;
    mon_on = 1;
    for (int e = 1; e <= 6; e++) begin
      set_tclk(1'b1);
      rd(2'd0, v);
      check("R10 no edge lost", int'(v), e);
      set_tclk(1'b0);
    end
    mon_on = 0;
    check("R10 steps seen", mon_steps, 6);
    check("R10 common phase", mon_bad, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule